// File: doc/BRIEF.md
# OFDM Pilot Polarity Sequencer

This block supplies the sign of each of the four pilot tones in every data symbol of a 64-point OFDM receiver. A 127-symbol pseudo-random polarity sequence steps forward once per symbol. In legacy mode all four pilots carry the same sequence bit, with a fixed inversion on one tone. In high-throughput (HT) mode, the sequence bit is XORed with a 4-bit per-tone pattern that rotates once per symbol.

The receiver pulses `sym_adv_i` at the start of each data symbol. The block then registers a fresh 4-bit vector for that symbol. As the pilots of the symbol arrive, the receiver pulses `pilot_shift_i`, and the vector rotates so that `pol_bit_o` always holds the sign for the next pilot. A 0 on that bit means the pilot is only conjugated, giving (I, -Q). A 1 means it is negated and conjugated, giving (-I, Q).

The receiver may find that the symbol it just advanced over was in fact an HT signal field. It then pulses `ht_enter_i`. This sets HT mode and steps the sequence back by one position, so the next advance uses the same sequence bit again.

Top module: `pilot_polarity_seq`

## Requirements
- R1: While `rst_n` is low and right after it, `pol_vec_o` is 4'b0000 and `pol_bit_o` is 0, and the block is in legacy mode. The HT pattern holds 4'b1000 and the sequence stands at position 0.
- R2: The sequence bit at position n is o(n), where o(n) = o(n-7) XOR o(n-4) for n >= 0, and o(-1) through o(-7) are all 1. Each `sym_adv_i` moves the position forward by one. The position wraps after 127, so symbol 127 reuses position 0.
- R3: On `sym_adv_i` in legacy mode, the vector is loaded from p, the bit at the position before it advances. The vector is {p, p, ~p, p}. Bit 3 is tone -7, bit 2 is tone -21, bit 1 is tone +21 and bit 0 is tone +7.
- R4: On `sym_adv_i` in HT mode, with pattern bits h[3:0], the vector is {h[1]^p, h[0]^p, h[3]^p, h[2]^p}. The pattern used is the value held before the advance.
- R5: The HT pattern rotates right by one place on each `sym_adv_i` in HT mode. It never changes in legacy mode.
- R6: An `ht_enter_i` pulse while in legacy mode sets HT mode and moves the sequence back one position. HT mode lasts until reset. An `ht_enter_i` pulse in HT mode has no effect.
- R7: Each `pilot_shift_i` pulse rotates the vector right by one bit. `pol_bit_o` always equals bit 0 of the vector.
- R8: When `sym_adv_i` and `pilot_shift_i` arrive in the same cycle, only the advance takes effect.
- R9: When `sym_adv_i` and `ht_enter_i` arrive in the same cycle, only the advance takes effect. The mode and the sequence position are left as the advance alone would leave them.
- R10: In a cycle with no strobe, the outputs hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sym_adv_i | input | 1 | Start of a data symbol: load the vector and advance the sequence |
| pilot_shift_i | input | 1 | A pilot has been consumed: rotate the vector |
| ht_enter_i | input | 1 | Switch into HT mode with a one-step sequence correction |
| pol_vec_o | output | 4 | Polarity bits for tones -7, -21, +21, +7 (bits 3..0) |
| pol_bit_o | output | 1 | Polarity of the next pilot to arrive |

## Verification
The hardest condition to reach from the ports is the step-back on HT entry. It shows only at the next advance, and only where the sequence bits on either side of the current position differ. It is also easily hidden by a same-cycle advance. The bench first walks the legacy sequence across its full 127-symbol period and checks the wrap. It then plays a fixed list of strobe combinations: HT entry alone, HT entry together with an advance, and a repeated HT entry. A sequence model built from the recurrence supplies the expected vector after each step.

// File: rtl/pps_pkg.sv
package pps_pkg;

  localparam int SEQ_LEN    = 127;
  localparam int GEN_W      = 7;
  localparam int TAP_HI     = 7;
  localparam int TAP_LO     = 4;
  localparam int NUM_PILOTS = 4;
  localparam int SEL_W      = $clog2(NUM_PILOTS);

  localparam logic [NUM_PILOTS-1:0] PAT_INIT = 4'b1000;

  // pattern bit feeding each vector bit: v0(+7)<-2, v1(+21)<-3, v2(-21)<-0, v3(-7)<-1
  localparam logic [NUM_PILOTS*SEL_W-1:0] PAT_SEL = {2'd1, 2'd0, 2'd3, 2'd2};

  // legacy tones that carry the inverted sequence bit (+21 only)
  localparam logic [NUM_PILOTS-1:0] LEGACY_FLIP = 4'b0010;

  typedef enum logic {MODE_LEGACY = 1'b0, MODE_HT = 1'b1} mode_e;

  // polarity sequence: output of a 7-stage generator x^7 + x^4 + 1 seeded all ones
  function automatic logic [SEQ_LEN-1:0] gen_seq();
    logic [GEN_W-1:0]   st;
    logic               fb;
    logic [SEQ_LEN-1:0] res;
    st  = '1;
    res = '0;
    for (int k = 0; k < SEQ_LEN; k++) begin
      fb     = st[TAP_HI-1] ^ st[TAP_LO-1];
      res[k] = fb;
      st     = {st[GEN_W-2:0], fb};
    end
    return res;
  endfunction

  localparam logic [SEQ_LEN-1:0] SEQ_INIT = gen_seq();

endpackage

// File: rtl/pps_seq_ring.sv
module pps_seq_ring #(
  parameter int                 LEN  = pps_pkg::SEQ_LEN,
  parameter logic [LEN-1:0]     INIT = pps_pkg::SEQ_INIT
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fwd_i,
  input  logic back_i,
  output logic cur_o,
  output logic prev_o
);

  localparam int ONES = $countones(INIT);

  logic [LEN-1:0] seq_q, seq_d;
  logic           seq_en;

  always_comb begin
    seq_en = fwd_i | back_i;
    if (fwd_i) seq_d = {seq_q[0], seq_q[LEN-1:1]};
    else       seq_d = {seq_q[LEN-2:0], seq_q[LEN-1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      seq_q <= INIT;
    else if (seq_en) seq_q <= seq_d;
  end

  assign cur_o  = seq_q[0];
  assign prev_o = seq_q[LEN-1];

  // R2: rotation keeps the sequence content intact
  a_r2_weight_kept: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(seq_q) == ONES);

  // R9: controller never asks for both directions at once
  a_r9_no_dual_step: assert property (@(posedge clk) disable iff (!rst_n)
    !(fwd_i && back_i));

endmodule

// File: rtl/pps_ht_rotor.sv
module pps_ht_rotor #(
  parameter int             W    = pps_pkg::NUM_PILOTS,
  parameter logic [W-1:0]   INIT = pps_pkg::PAT_INIT
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rot_i,
  output logic [W-1:0] pat_o
);

  logic [W-1:0] pat_q, pat_d;

  always_comb pat_d = {pat_q[0], pat_q[W-1:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pat_q <= INIT;
    else if (rot_i) pat_q <= pat_d;
  end

  assign pat_o = pat_q;

  // R5: the pattern keeps a single set bit
  a_r5_single_bit: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(pat_q) == 1);

  // R5: no movement without a rotate request
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rot_i |=> $stable(pat_q));

endmodule

// File: rtl/pps_pilot_vec.sv
module pps_pilot_vec #(
  parameter int                       NP    = pps_pkg::NUM_PILOTS,
  parameter int                       SW    = pps_pkg::SEL_W,
  parameter logic [NP*SW-1:0]         SEL   = pps_pkg::PAT_SEL,
  parameter logic [NP-1:0]            FLIP  = pps_pkg::LEGACY_FLIP
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          shift_i,
  input  logic          p_i,
  input  logic          ht_i,
  input  logic [NP-1:0] pat_i,
  output logic [NP-1:0] vec_o
);

  logic [NP-1:0] fresh;
  logic [NP-1:0] vec_q, vec_d;
  logic          vec_en;

  for (genvar t = 0; t < NP; t++) begin : g_tone
    localparam logic [SW-1:0] PSEL = SEL[t*SW +: SW];
    assign fresh[t] = ht_i ? (pat_i[PSEL] ^ p_i) : (p_i ^ FLIP[t]);
  end

  always_comb begin
    vec_en = load_i | shift_i;
    if (load_i) vec_d = fresh;
    else        vec_d = {vec_q[0], vec_q[NP-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      vec_q <= '0;
    else if (vec_en) vec_q <= vec_d;
  end

  assign vec_o = vec_q;

  // R8: the controller resolves the advance/shift collision before this point
  a_r8_one_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_i && shift_i));

endmodule

// File: rtl/pilot_polarity_seq.sv
module pilot_polarity_seq
  import pps_pkg::*;
#(
  parameter int NP = pps_pkg::NUM_PILOTS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sym_adv_i,
  input  logic          pilot_shift_i,
  input  logic          ht_enter_i,
  output logic [NP-1:0] pol_vec_o,
  output logic          pol_bit_o
);

  mode_e         mode_q, mode_d;
  logic          mode_en;
  logic          is_ht;
  logic          adv, shift, enter;
  logic          cur_bit, prev_bit;
  logic [NP-1:0] pat;

  assign is_ht = (mode_q == MODE_HT);

  // command arbitration: symbol advance wins over both other strobes
  always_comb begin
    adv     = sym_adv_i;
    shift   = pilot_shift_i & ~sym_adv_i;
    enter   = ht_enter_i & ~sym_adv_i & ~is_ht;
    mode_en = enter;
    mode_d  = MODE_HT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= MODE_LEGACY;
    else if (mode_en) mode_q <= mode_d;
  end

  pps_seq_ring #(.LEN(SEQ_LEN), .INIT(SEQ_INIT)) u_ring (
    .clk    (clk),
    .rst_n  (rst_n),
    .fwd_i  (adv),
    .back_i (enter),
    .cur_o  (cur_bit),
    .prev_o (prev_bit)
  );

  pps_ht_rotor #(.W(NP), .INIT(PAT_INIT)) u_rotor (
    .clk   (clk),
    .rst_n (rst_n),
    .rot_i (adv & is_ht),
    .pat_o (pat)
  );

  pps_pilot_vec #(.NP(NP), .SW(SEL_W), .SEL(PAT_SEL), .FLIP(LEGACY_FLIP)) u_vec (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (adv),
    .shift_i (shift),
    .p_i     (cur_bit),
    .ht_i    (is_ht),
    .pat_i   (pat),
    .vec_o   (pol_vec_o)
  );

  assign pol_bit_o = pol_vec_o[0];

  // R3: legacy vectors have three equal tones and an inverted +21 tone
  a_r3_legacy_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_adv_i && !is_ht) |=> (pol_vec_o[3] == pol_vec_o[2]) &&
                              (pol_vec_o[2] == pol_vec_o[0]) &&
                              (pol_vec_o[1] != pol_vec_o[0]));

  // R7: a lone pilot strobe rotates the vector right
  a_r7_rotate: assert property (@(posedge clk) disable iff (!rst_n)
    (pilot_shift_i && !sym_adv_i) |=>
      pol_vec_o == {$past(pol_vec_o[0]), $past(pol_vec_o[NP-1:1])});

  // R6: HT mode is sticky
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    is_ht |=> is_ht);

  // R6: HT entry steps the sequence back by one position
  a_r6_step_back: assert property (@(posedge clk) disable iff (!rst_n)
    enter |=> cur_bit == $past(prev_bit));

  // R9: an advance in the same cycle blocks the mode switch
  a_r9_adv_blocks_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_adv_i && !is_ht) |=> !is_ht);

  // R10: outputs hold without a strobe
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!sym_adv_i && !pilot_shift_i) |=> $stable(pol_vec_o));

endmodule

// File: tb/pilot_polarity_seq_bench.sv
`timescale 1ns/1ps
module pilot_polarity_seq_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       sym_adv_i, pilot_shift_i, ht_enter_i;
  logic [3:0] pol_vec_o;
  logic       pol_bit_o;

  always #2.5 clk = ~clk;

  pilot_polarity_seq u_pilot_polarity_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .sym_adv_i     (sym_adv_i),
    .pilot_shift_i (pilot_shift_i),
    .ht_enter_i    (ht_enter_i),
    .pol_vec_o     (pol_vec_o),
    .pol_bit_o     (pol_bit_o)
  );

  // op bits: [0] advance, [1] pilot shift, [2] HT entry
  localparam int NOPS = 24;
  localparam logic [2:0] OPS [NOPS] = '{
    3'b001, 3'b010, 3'b010, 3'b011, 3'b000, 3'b101, 3'b001, 3'b100,
    3'b001, 3'b010, 3'b010, 3'b010, 3'b010, 3'b001, 3'b001, 3'b001,
    3'b001, 3'b001, 3'b100, 3'b001, 3'b000, 3'b011, 3'b110, 3'b001
  };

  int   n_checks = 0;
  int   n_fail   = 0;
  bit   hist [134];
  int   pos;
  bit   m_ht;
  logic [3:0] m_pat, m_vec, first_vec;

  function automatic bit seq_bit(int n);
    return hist[n + 7];
  endfunction

  function automatic logic [3:0] build(bit p, bit ht, logic [3:0] h);
    if (ht) return {h[1] ^ p, h[0] ^ p, h[3] ^ p, h[2] ^ p};
    return {p, p, ~p, p};
  endfunction

  function automatic string tag_of(logic [2:0] op);
    case (op)
      3'b011:  return "R8";
      3'b101:  return "R9";
      3'b100:  return "R6";
      3'b110:  return "R6 R7";
      3'b010:  return "R7";
      3'b000:  return "R10";
      default: return m_ht ? "R4 R5" : "R2 R3";
    endcase
  endfunction

  task automatic check(string tag, logic [4:0] exp);
    logic [4:0] act;
    act = {pol_bit_o, pol_vec_o};
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    pos = 0; m_ht = 0; m_pat = 4'b1000; m_vec = 4'b0000;
  endtask

  task automatic step(logic [2:0] op);
    string t;
    t = tag_of(op);
    @(negedge clk);
    sym_adv_i = op[0]; pilot_shift_i = op[1]; ht_enter_i = op[2];
    @(negedge clk);
    sym_adv_i = 0; pilot_shift_i = 0; ht_enter_i = 0;
    if (op[0]) begin
      m_vec = build(seq_bit(pos), m_ht, m_pat);
      if (m_ht) m_pat = {m_pat[0], m_pat[3:1]};
      pos = (pos + 1) % 127;
    end else begin
      if (op[2] && !m_ht) begin
        m_ht = 1;
        pos  = (pos + 126) % 127;
      end
      if (op[1]) m_vec = {m_vec[0], m_vec[3:1]};
    end
    check(t, {m_vec[0], m_vec});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    repeat (2) @(negedge clk);
    check("R1 during reset", 5'b00000);
    rst_n = 1;
    model_reset();
    @(negedge clk);
    check("R1 after reset", 5'b00000);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst_n = 0; sym_adv_i = 0; pilot_shift_i = 0; ht_enter_i = 0;
    for (int k = 0; k < 7; k++) hist[k] = 1;
    for (int k = 7; k < 134; k++) hist[k] = hist[k-7] ^ hist[k-4];
    model_reset();
    do_reset();

    // R7: shifting the reset vector leaves it zero
    step(3'b010);

    // R2 R3: full legacy period, with a pilot pass inside symbol 4
    for (int s = 0; s < 127; s++) begin
      step(3'b001);
      if (s == 0) first_vec = m_vec;
      if (s == 4) for (int k = 0; k < 4; k++) step(3'b010);
    end
    // R2: symbol 127 wraps to position 0
    step(3'b001);
    check("R2 wrap", {first_vec[0], first_vec});

    // R4 R5 R6 R8 R9 R10: directed strobe table
    for (int i = 0; i < NOPS; i++) step(OPS[i]);

    // R1: reset in HT mode returns to legacy, pattern and position 0
    do_reset();
    step(3'b001);
    check("R1 first symbol after reset", {1'b0, 4'b0010});
    step(3'b100);
    step(3'b001);
    step(3'b001);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule